// File: doc/BRIEF.md
# Loopback Modem Status Generator

This block produces the 8-bit modem status register value of a serial port while the port is wired back onto itself for self-test. In every clock of loopback operation it copies four modem-control outputs onto the four modem-status lines. It compares each copied line with the status currently held and records changes in sticky delta bits. Those delta bits are what a modem-status interrupt source downstream looks at. When the port is not in loopback, the status lines never move, so no change is ever reported. A read of the status register by the register interface pulses a strobe, and that strobe clears the whole register.

The mode is held in a two-state machine, `MODE_DIRECT` and `MODE_MIRROR`. The loop-enable bit (control bit 4) is registered on every edge. The transition `ENTER_LOOP` (DIRECT to MIRROR) is taken when that bit is 1, and `LEAVE_LOOP` (MIRROR to DIRECT) when it is 0. Otherwise the state is held (`STAY`). An edge only mirrors when the state at that edge was `MODE_MIRROR`. So a change of the loop bit takes effect from the following edge.

Top module: `msr_loopback_gen`

## Requirements
- R1: After reset the status output is 0x00 and the state is `MODE_DIRECT`. A control value presented in the first cycle after reset therefore changes nothing.
- R2: In `MODE_MIRROR`, at each edge status bit 7 takes control bit 3, and status bit 6 takes control bit 2. The result is visible on the output after that edge.
- R3: In `MODE_MIRROR`, at each edge status bit 5 takes control bit 0, and status bit 4 takes control bit 1.
- R4: In `MODE_MIRROR`, a delta bit is set when the newly copied line differs from the status bit held before that edge. The bits are: bit 3 for line 7, bit 1 for line 5, and bit 0 for line 4.
- R5: In `MODE_MIRROR`, delta bit 2 is set only when the held status bit 6 is 1 and control bit 2 is 0. A rising line 6 sets nothing.
- R6: Delta bits stay set until the clear strobe. A clear strobe in `MODE_DIRECT` makes the whole output 0x00.
- R7: In `MODE_DIRECT`, the output holds its value whatever the control input does, unless a clear strobe arrives. The state follows control bit 4 one edge later.
- R8: When a clear strobe and a new delta fall on the same edge in `MODE_MIRROR`, the new delta survives, older deltas are cleared, and the status lines show the copied values.
- R9: A single control change sets its delta once. Holding the control value steady after a clear sets no delta.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_in | input | 8 | Modem-control register value; bit 4 enables loopback |
| rd_clr | input | 1 | One-cycle strobe when the status register is read |
| stat_o | output | 8 | Modem status register value |

## Verification
The hardest case to reach is the one where a clear strobe lands on the same edge as a fresh line change. The stimulus first lets one delta build up, then drops a second control bit in the very cycle the clear strobe is raised. The survivor and the cleared bit can then be told apart. The trailing-edge ring delta needs its own sequence: line 6 is raised, cleared, dropped and raised again, which shows that only the fall sets it. Leaving loopback is checked over the one edge where the old state still mirrors. After that, the control bits are toggled to show that nothing moves.

// File: rtl/msr_loop_pkg.sv
package msr_loop_pkg;

    localparam int REG_W     = 8;
    localparam int NUM_LINES = 4;
    localparam int LOOP_BIT  = 4;

    typedef enum logic {
        MODE_DIRECT = 1'b0,
        MODE_MIRROR = 1'b1
    } mode_e;

    typedef enum logic {
        DET_ANY  = 1'b0,
        DET_FALL = 1'b1
    } det_e;

    // Per-line maps, line order: clear-to-send, set-ready, ring, carrier
    localparam int unsigned CTRL_BIT  [NUM_LINES] = '{1, 0, 2, 3};
    localparam int unsigned STAT_BIT  [NUM_LINES] = '{4, 5, 6, 7};
    localparam int unsigned DELTA_BIT [NUM_LINES] = '{0, 1, 2, 3};
    localparam det_e        DET_KIND  [NUM_LINES] = '{DET_ANY, DET_ANY, DET_FALL, DET_ANY};

endpackage

// File: rtl/msr_line_mirror.sv
module msr_line_mirror
    import msr_loop_pkg::*;
(
    input  logic [REG_W-1:0]     ctrl_i,
    output logic [NUM_LINES-1:0] line_o
);

    logic unused_ctrl;
    assign unused_ctrl = ^ctrl_i;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_map
        assign line_o[g] = ctrl_i[CTRL_BIT[g]];
    end

endmodule

// File: rtl/msr_delta_detect.sv
module msr_delta_detect
    import msr_loop_pkg::*;
(
    input  logic [NUM_LINES-1:0] line_new_i,
    input  logic [NUM_LINES-1:0] line_cur_i,
    output logic [NUM_LINES-1:0] delta_o
);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_det
        if (DET_KIND[g] == DET_FALL) begin : g_fall
            assign delta_o[g] = line_cur_i[g] & ~line_new_i[g];
        end else begin : g_any
            assign delta_o[g] = line_cur_i[g] ^ line_new_i[g];
        end
    end

endmodule

// File: rtl/msr_loopback_gen.sv
module msr_loopback_gen
    import msr_loop_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] ctrl_in,
    input  logic             rd_clr,
    output logic [REG_W-1:0] stat_o
);

    mode_e                state_q, state_d;
    logic [REG_W-1:0]     msr_q, msr_d;
    logic [NUM_LINES-1:0] line_new, line_cur, delta_new;

    msr_line_mirror u_mirror (
        .ctrl_i (ctrl_in),
        .line_o (line_new)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_cur
        assign line_cur[g] = msr_q[STAT_BIT[g]];
    end

    msr_delta_detect u_detect (
        .line_new_i (line_new),
        .line_cur_i (line_cur),
        .delta_o    (delta_new)
    );

    // State transitions: ENTER_LOOP, LEAVE_LOOP, STAY
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_DIRECT: if (ctrl_in[LOOP_BIT])  state_d = MODE_MIRROR;
            MODE_MIRROR: if (!ctrl_in[LOOP_BIT]) state_d = MODE_DIRECT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_DIRECT;
        else        state_q <= state_d;
    end

    // Register contents for each state
    always_comb begin
        msr_d = msr_q;
        unique case (state_q)
            MODE_DIRECT: begin
                if (rd_clr) msr_d = '0;
            end
            MODE_MIRROR: begin
                for (int i = 0; i < NUM_LINES; i++) begin
                    msr_d[STAT_BIT[i]]  = line_new[i];
                    msr_d[DELTA_BIT[i]] = (msr_q[DELTA_BIT[i]] & ~rd_clr) | delta_new[i];
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) msr_q <= '0;
        else        msr_q <= msr_d;
    end

    assign stat_o = msr_q;

    // Checks next to the logic they guard
    a_r7_direct_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_DIRECT && !rd_clr) |=> $stable(stat_o));

    a_r6_direct_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_DIRECT && rd_clr) |=> (stat_o == '0));

    a_r2_carrier_ring: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_MIRROR) |=>
            (stat_o[7] == $past(ctrl_in[3]) && stat_o[6] == $past(ctrl_in[2])));

    a_r3_ready_cts: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_MIRROR) |=>
            (stat_o[5] == $past(ctrl_in[0]) && stat_o[4] == $past(ctrl_in[1])));

    a_r4_carrier_delta: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_MIRROR && ctrl_in[3] != stat_o[7]) |=> stat_o[3]);

    a_r5_ring_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_MIRROR && stat_o[6] && !ctrl_in[2]) |=> stat_o[2]);

    a_r5_ring_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ((!stat_o[2] || rd_clr) && !(state_q == MODE_MIRROR && stat_o[6] && !ctrl_in[2]))
            |=> !stat_o[2]);

    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr |=> ((stat_o[3:0] & $past(stat_o[3:0])) == $past(stat_o[3:0])));

endmodule

// File: tb/msr_loopback_gen_tb.sv
module msr_loopback_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] ctrl_in;
    logic       rd_clr;
    logic [7:0] stat_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    msr_loopback_gen dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_in (ctrl_in),
        .rd_clr  (rd_clr),
        .stat_o  (stat_o)
    );

    // {requirement index, ctrl, clear, expected}
    localparam int NV = 17;
    localparam logic [20:0] VEC [NV] = '{
        {4'd7, 8'h0F, 1'b0, 8'h00},
        {4'd7, 8'h1F, 1'b0, 8'h00},
        {4'd4, 8'h1F, 1'b0, 8'hFB},
        {4'd9, 8'h1F, 1'b1, 8'hF0},
        {4'd9, 8'h1F, 1'b0, 8'hF0},
        {4'd5, 8'h1B, 1'b0, 8'hB4},
        {4'd6, 8'h1B, 1'b0, 8'hB4},
        {4'd5, 8'h1F, 1'b0, 8'hF4},
        {4'd6, 8'h1F, 1'b1, 8'hF0},
        {4'd3, 8'h1D, 1'b0, 8'hE1},
        {4'd8, 8'h1C, 1'b1, 8'hC2},
        {4'd2, 8'h14, 1'b0, 8'h4A},
        {4'd7, 8'h04, 1'b0, 8'h4A},
        {4'd7, 8'h00, 1'b0, 8'h4A},
        {4'd7, 8'h0F, 1'b0, 8'h4A},
        {4'd6, 8'h00, 1'b1, 8'h00},
        {4'd7, 8'h0F, 1'b0, 8'h00}
    };

    function automatic string req_name(input logic [3:0] k);
        case (k)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] exp);
        n_chk++;
        if (stat_o !== exp) begin
            n_bad++;
            $display("FAIL %s: stat_o=%02h expected %02h", req, stat_o, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic apply(input logic [7:0] c, input logic r);
        ctrl_in = c;
        rd_clr  = r;
        @(negedge clk);
    endtask

    initial begin
        rst_n   = 1'b0;
        ctrl_in = 8'h00;
        rd_clr  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 8'h00);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][16:9], VEC[i][8]);
            check(req_name(VEC[i][20:17]), VEC[i][7:0]);
        end

        // enter loopback, build up a value, then reset mid-run (R1)
        apply(8'h1F, 1'b0);
        apply(8'h1F, 1'b0);
        check("R2", 8'hFB);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", 8'h00);
        rst_n = 1'b1;
        // state is direct after reset: first loop-enabled cycle mirrors nothing (R1)
        apply(8'h1F, 1'b0);
        check("R1", 8'h00);
        apply(8'h1F, 1'b0);
        check("R4", 8'hFB);
        // clear and a fresh ring fall on the same edge (R8)
        apply(8'h1B, 1'b1);
        check("R8", 8'hB4);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule